// File: doc/BRIEF.md
# Shared Interrupt Line Merger

This block folds the level-sensitive interrupt requests of a row of device slots onto four shared request lines. Every slot drives four request pins, numbered 0 to 3. The block keeps the most recently sampled level of each pin. A pin moves the count of the line it is routed to only when its sampled level differs from the stored one: a rise adds one and a fall subtracts one. A shared line is driven high whenever its count is above zero.

Routing rotates with the slot position. Pin `p` of slot `s` drives line `(p + s) mod 4`, so the first pins of neighbouring slots spread across different lines. All pins are sampled on every clock. When several pins change in the same cycle, all of their changes are applied to the line counts in that one cycle.

Each line owns a two-state controller. `LINE_IDLE` moves to `LINE_ASSERTED` by the raise transition, taken when the line's next count is nonzero. `LINE_ASSERTED` returns to `LINE_IDLE` by the release transition, taken when the next count is zero. In either state the controller otherwise holds. The line output is high exactly in `LINE_ASSERTED`.

Top module: `irq_line_merge`

## Requirements
- R1: While `rst_n` is low, every stored pin level and every line count is zero and all of `line_o` is low, whatever `irq_i` carries.
- R2: Pin `p` of slot `s`, carried on `irq_i[s*4+p]`, is routed to `line_o[(p+s) mod 4]`.
- R3: Each line count equals the number of pins routed to that line whose stored level is high. It never drops below zero and never exceeds the number of slots. The line stays high while any such pin remains high.
- R4: A line goes low in the cycle after the last high pin routed to it is sampled low.
- R5: Rises and falls of several pins sampled at the same edge are all applied to the line counts at that edge. A rise and a fall on the same line in one cycle leave that line's state unchanged.
- R6: A pin whose sampled level equals its stored level has no effect. Holding a pin high for many cycles adds only one to its line's count, so a single fall clears it.
- R7: `line_o` is a registered output. A change on `irq_i` shows on `line_o` only after the next rising clock edge, never before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SLOTS*4 | Pin levels; bit s*4+p is pin p of slot s |
| line_o | output | 4 | Shared request lines, high while the line count is nonzero |

## Verification
The assertions assume that `irq_i` is stable around each rising edge. They also assume that every change in the pin levels is observed through the stored copy, so the counters stay in step with the number of high pins. The stability check on `line_o` is armed one edge after reset ends, because a pin held high through reset counts as a rise at the first edge. The stimulus drives `irq_i` only on falling edges and releases reset with all pins low. It then runs walks over single pins, stacking and simultaneous changes on one line, long holds, and seeded random patterns. None of this breaks those assumptions.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

    localparam int PINS_PER_SLOT = 4;
    localparam int NUM_LINES     = 4;

    typedef enum logic {
        LINE_IDLE     = 1'b0,
        LINE_ASSERTED = 1'b1
    } line_state_e;

    // Rotation: pin p of slot s lands on line (p + s) mod 4
    function automatic int unsigned line_of(int unsigned slot, int unsigned pin);
        return (slot + pin) % NUM_LINES;
    endfunction

endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
    import irq_merge_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PINS_PER_SLOT-1:0] pin_i,
    output logic [PINS_PER_SLOT-1:0] rise_o,
    output logic [PINS_PER_SLOT-1:0] fall_o
);

    logic [PINS_PER_SLOT-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= pin_i;
        end
    end

    // Only a difference from the stored level produces a delta
    always_comb begin
        rise_o = pin_i & ~level_q;
        fall_o = ~pin_i & level_q;
    end

    // R6: a reported rise must leave the stored level high afterwards
    p_rise_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> (|level_q));

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_merge_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 5
) (
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] rise_i,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] fall_i,
    output logic [NUM_LINES-1:0][CNT_W-1:0]    up_o,
    output logic [NUM_LINES-1:0][CNT_W-1:0]    down_o
);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        always_comb begin
            up_o[l]   = '0;
            down_o[l] = '0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                for (int p = 0; p < PINS_PER_SLOT; p++) begin
                    if (line_of(s, p) == l) begin
                        up_o[l]   = up_o[l]   + CNT_W'(rise_i[s*PINS_PER_SLOT+p]);
                        down_o[l] = down_o[l] + CNT_W'(fall_i[s*PINS_PER_SLOT+p]);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
    import irq_merge_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] up_i,
    input  logic [CNT_W-1:0] down_i,
    output logic             line_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_SLOTS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    line_state_e      state_q;
    line_state_e      state_d;

    always_comb begin
        cnt_d = cnt_q + up_i - down_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE: begin
                if (cnt_d != '0) state_d = LINE_ASSERTED;   // raise
            end
            LINE_ASSERTED: begin
                if (cnt_d == '0) state_d = LINE_IDLE;       // release
            end
            default: state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            state_q <= LINE_IDLE;
        end else begin
            cnt_q   <= cnt_d;
            state_q <= state_d;
        end
    end

    always_comb begin
        line_o = (state_q == LINE_ASSERTED);
    end

    // R3: the count never goes below zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} + {1'b0, up_i}) >= {1'b0, down_i});

    // R3: the count never exceeds one pin per slot
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_CNT);

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
    import irq_merge_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] irq_i,
    output logic [NUM_LINES-1:0]               line_o
);

    localparam int IRQ_W = NUM_SLOTS * PINS_PER_SLOT;
    localparam int CNT_W = $clog2(IRQ_W + 1);

    logic [IRQ_W-1:0]                 rise;
    logic [IRQ_W-1:0]                 fall;
    logic [NUM_LINES-1:0][CNT_W-1:0]  up_cnt;
    logic [NUM_LINES-1:0][CNT_W-1:0]  down_cnt;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        irq_pin_tracker u_tracker (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (irq_i[s*PINS_PER_SLOT +: PINS_PER_SLOT]),
            .rise_o (rise[s*PINS_PER_SLOT +: PINS_PER_SLOT]),
            .fall_o (fall[s*PINS_PER_SLOT +: PINS_PER_SLOT])
        );
    end

    irq_line_router #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W)
    ) u_router (
        .rise_i (rise),
        .fall_i (fall),
        .up_o   (up_cnt),
        .down_o (down_cnt)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_cnt
        irq_line_counter #(
            .NUM_SLOTS (NUM_SLOTS),
            .CNT_W     (CNT_W)
        ) u_counter (
            .clk    (clk),
            .rst_n  (rst_n),
            .up_i   (up_cnt[l]),
            .down_i (down_cnt[l]),
            .line_o (line_o[l])
        );
    end

    // ---------------- checks across the submodules ----------------

    function automatic logic [IRQ_W-1:0] line_mask(int unsigned line);
        logic [IRQ_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < PINS_PER_SLOT; p++) begin
                if (line_of(s, p) == line) m[s*PINS_PER_SLOT+p] = 1'b1;
            end
        end
        return m;
    endfunction

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk_slot
        for (genvar p = 0; p < PINS_PER_SLOT; p++) begin : g_chk_pin
            // R2: a high pin holds its rotated line high after the edge
            p_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
                irq_i[s*PINS_PER_SLOT+p] |=> line_o[(s + p) % NUM_LINES]);
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk_line
        localparam logic [IRQ_W-1:0] MASK = line_mask(l);
        // R4: no high pin on this line means the line is low after the edge
        p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((irq_i & MASK) == '0) |=> !line_o[l]);
    end

    // R6: unchanged pins leave every line unchanged
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $stable(irq_i)) |=> $stable(line_o));

endmodule

// File: tb/tb_irq_line_merge.sv
module tb_irq_line_merge;

    localparam int NS    = 4;
    localparam int IRQ_W = NS * 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [IRQ_W-1:0] irq;
    logic [3:0]       line_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int lvl [IRQ_W];
    int cnt [4];

    always #5 clk = ~clk;

    irq_line_merge #(.NUM_SLOTS(NS)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq),
        .line_o (line_o)
    );

    task automatic check_lines(string req);
        for (int l = 0; l < 4; l++) begin
            logic exp;
            exp = (cnt[l] != 0);
            checks++;
            if (line_o[l] !== exp) begin
                errors++;
                $display("FAIL %s line %0d actual=%b expected=%b", req, l, line_o[l], exp);
            end
        end
    endtask

    task automatic model_edge(logic [IRQ_W-1:0] v);
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < 4; p++) begin
                int idx;
                int nv;
                idx = s * 4 + p;
                nv  = v[idx] ? 1 : 0;
                if (nv != lvl[idx]) begin
                    cnt[(s + p) % 4] += (nv == 1) ? 1 : -1;
                    lvl[idx] = nv;
                end
            end
        end
        for (int l = 0; l < 4; l++) begin
            checks++;
            if (cnt[l] < 0 || cnt[l] > NS) begin
                errors++;
                $display("FAIL R3 model count line %0d actual=%0d expected=0..%0d", l, cnt[l], NS);
            end
        end
    endtask

    // Drive at a falling edge, check before and after the next rising edge
    task automatic step(logic [IRQ_W-1:0] v, string req);
        irq = v;
        #1;
        check_lines({req, " R7 pre-edge"});
        @(posedge clk);
        model_edge(v);
        @(negedge clk);
        check_lines(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [IRQ_W-1:0] v;
        for (int i = 0; i < IRQ_W; i++) lvl[i] = 0;
        for (int l = 0; l < 4; l++) cnt[l] = 0;

        // R1: reset holds everything low even with all pins high
        rst_n = 1'b0;
        irq   = '1;
        repeat (3) @(negedge clk);
        check_lines("R1 in reset");
        irq = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_lines("R1 after release");

        // R2: walk each pin alone
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < 4; p++) begin
                step(IRQ_W'(1) << (s * 4 + p), "R2 walk raise");
                step('0, "R2 walk drop");
            end
        end

        // R3/R4: stack the pins of line 0 (indices 0, 7, 10, 13)
        v = '0;
        v[0] = 1'b1;  step(v, "R3 stack");
        v[7] = 1'b1;  step(v, "R3 stack");
        v[10] = 1'b1; step(v, "R3 stack");
        v[13] = 1'b1; step(v, "R3 stack");
        v[0] = 1'b0;  step(v, "R3 partial drop");
        v[7] = 1'b0;  step(v, "R3 partial drop");
        v[10] = 1'b0; step(v, "R3 partial drop");
        v[13] = 1'b0; step(v, "R4 last drop");

        // R5: simultaneous changes on one line
        v = '0;
        v[0] = 1'b1; v[7] = 1'b1; step(v, "R5 double raise");
        v[0] = 1'b0; v[10] = 1'b1; step(v, "R5 raise and fall");
        v[7] = 1'b0; v[10] = 1'b0; step(v, "R5 double fall");
        step('1, "R5 all raise");
        step('0, "R5 all fall");

        // R6: long hold counts once, single drop clears
        v = '0;
        v[5] = 1'b1;
        for (int i = 0; i < 20; i++) step(v, "R6 hold");
        step('0, "R6 drop after hold");

        // R3: seeded random traffic
        void'($urandom(32'h1d2c));
        for (int i = 0; i < 400; i++) begin
            step(IRQ_W'($urandom), "R3 random");
        end
        step('0, "R4 final clear");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule